// File: doc/BRIEF.md
# Subclass-Masked I/O Interrupt Queue

This block holds pending I/O interruption requests for a processor, sorted into eight interruption subclasses. Each subclass has its own last-in-first-out stack with a configurable depth. Each entry has four fields: a 16-bit subchannel identifier, a 16-bit subchannel number, a 32-bit interruption parameter and a 32-bit interruption word. The entry's subclass is read from a field of its interruption word.

A 64-bit control register carries one enable bit per subclass. The block scans the subclasses from 0 upward and presents the top entry of the first subclass that holds entries and is enabled. When the interrupt selector raises a service request while the status word permits I/O interruptions, the presented entry is popped. A subclass that is disabled is passed over, but its entries stay queued. A summary output reports whether any entry is queued anywhere, whether masked or not.

A push to a full subclass is an overrun, and a service request while I/O interruptions are disabled is an error. In both cases a single-cycle error pulse is raised and the offending operation is dropped.

Top module: `io_irq_queue`

## Requirements
- R1: After reset every subclass is empty, and `pending`, `out_valid` and `err` are all low.
- R2: An entry's subclass is bits [29:27] of `push_word`. Subclass s is enabled when `ctrl_reg` bit (31 - s) is set, so subclass 0 uses bit 31 and subclass 7 uses bit 24.
- R3: `out_valid` is high and `out_subclass` names the lowest-numbered subclass that is both non-empty and enabled. The `out_*` fields are that subclass's top entry.
- R4: A disabled subclass that holds entries is never presented. Its entries remain queued, and they are presented once its enable bit is set.
- R5: Within one subclass, entries leave in the reverse of their arrival order.
- R6: A service request with `io_enable` high and `out_valid` high removes exactly the presented entry. The outputs reflect the removal in the next cycle.
- R7: A push to a subclass that already holds DEPTH entries, with no pop of that subclass in the same cycle, is dropped, and `err` is high for the next cycle only.
- R8: A service request while `io_enable` is low removes nothing, and `err` is high for the next cycle only.
- R9: `pending` is high while any subclass, enabled or not, holds an entry. It is low only when all subclasses are empty.
- R10: A service request with `io_enable` high and nothing deliverable changes nothing and raises no error.
- R11: A push and a pop of the same full subclass in the same cycle are both accepted: the top entry leaves and the new entry takes its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a new entry this cycle |
| push_id | input | 16 | Subchannel identifier of the new entry |
| push_nr | input | 16 | Subchannel number of the new entry |
| push_parm | input | 32 | Interruption parameter of the new entry |
| push_word | input | 32 | Interruption word; bits [29:27] give the subclass |
| ctrl_reg | input | 64 | Control register; bit 31-s enables subclass s |
| io_enable | input | 1 | I/O interruption enable from the status word |
| svc_req | input | 1 | Service request: deliver and pop the presented entry |
| out_valid | output | 1 | A deliverable entry is presented |
| out_subclass | output | 3 | Subclass of the presented entry |
| out_id | output | 16 | Subchannel identifier of the presented entry |
| out_nr | output | 16 | Subchannel number of the presented entry |
| out_parm | output | 32 | Interruption parameter of the presented entry |
| out_word | output | 32 | Interruption word of the presented entry |
| pending | output | 1 | Some subclass holds at least one entry |
| err | output | 1 | One-cycle pulse on an overrun or a service request while I/O is disabled |

## Verification
The bench keeps all masked subclasses loaded while a lower-priority subclass drains. A design that cleared `pending` once nothing was deliverable, or that delivered a masked entry, would fail here. It fills one subclass past its depth and then drains it. An overrun that slipped through would show up as an extra or corrupted entry, and a missing pulse as a silent `err`. It pushes and pops a full subclass in the same cycle, which trips a design that treats that case as an overrun or writes above the old top. It also issues service requests with I/O disabled and with nothing deliverable, expecting an error in the first case only.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int NUM_SUB  = 8;
    localparam int SUB_W    = 3;
    localparam int SUB_LSB  = 27;
    localparam int EN_TOP   = 31;

    typedef struct packed {
        logic [15:0] id;
        logic [15:0] nr;
        logic [31:0] parm;
        logic [31:0] word;
    } iq_entry_t;
endpackage

// File: rtl/iq_stack.sv
module iq_stack
    import iq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  iq_entry_t                    push_entry,
    output iq_entry_t                    top_entry,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        iq_entry_t [DEPTH-1:0] mem;
        logic [CW-1:0]         cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] wr_pos;
    logic [CW-1:0] top_pos;

    always_comb begin
        st_d   = st_q;
        wr_pos = st_q.cnt - CW'(pop);
        if (pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push) begin
            st_d.mem[IW'(wr_pos)] = push_entry;
            st_d.cnt              = wr_pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_pos   = st_q.cnt - 1'b1;
    assign top_entry = (st_q.cnt != '0) ? st_q.mem[IW'(top_pos)] : '0;
    assign count     = st_q.cnt;

    // R7: the push guard upstream never lets a full stack grow
    a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.cnt != FULL));

    // R6: a pop only reaches a stack that holds an entry
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    // R6: a lone pop lowers the fill level by one
    a_r6_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R11: push and pop together leave the fill level unchanged
    a_r11_swap_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push) |=> $stable(st_q.cnt));
endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
(
    input  logic [NUM_SUB-1:0] req,
    output logic               grant_valid,
    output logic [SUB_W-1:0]   grant_idx,
    output logic [NUM_SUB-1:0] grant_oh
);
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int s = NUM_SUB - 1; s >= 0; s--) begin
            if (req[s]) begin
                grant_valid = 1'b1;
                grant_idx   = SUB_W'(s);
            end
        end
        grant_oh = '0;
        if (grant_valid) begin
            grant_oh[grant_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/io_irq_queue.sv
module io_irq_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [15:0] push_id,
    input  logic [15:0] push_nr,
    input  logic [31:0] push_parm,
    input  logic [31:0] push_word,
    input  logic [63:0] ctrl_reg,
    input  logic        io_enable,
    input  logic        svc_req,
    output logic        out_valid,
    output logic [2:0]  out_subclass,
    output logic [15:0] out_id,
    output logic [15:0] out_nr,
    output logic [31:0] out_parm,
    output logic [31:0] out_word,
    output logic        pending,
    output logic        err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic err;
    } top_t;

    top_t              r_d, r_q;
    iq_entry_t         new_entry;
    iq_entry_t         tops [NUM_SUB];
    logic [CW-1:0]     cnt  [NUM_SUB];
    logic [NUM_SUB-1:0] sub_en, sub_busy, sub_full, sub_push, sub_pop;
    logic [SUB_W-1:0]  push_sub;
    logic              grant_valid;
    logic [SUB_W-1:0]  grant_idx;
    logic [NUM_SUB-1:0] grant_oh;
    logic              pop_fire, push_ok;

    assign new_entry = '{id: push_id, nr: push_nr, parm: push_parm, word: push_word};
    assign push_sub  = push_word[SUB_LSB +: SUB_W];

    iq_select u_sel (
        .req         (sub_busy & sub_en),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_oh    (grant_oh)
    );

    assign pop_fire = svc_req && io_enable && grant_valid;
    assign push_ok  = push_valid &&
                      (!sub_full[push_sub] || (pop_fire && grant_idx == push_sub));

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        assign sub_en[g]   = ctrl_reg[EN_TOP - g];
        assign sub_busy[g] = (cnt[g] != '0);
        assign sub_full[g] = (cnt[g] == FULL);
        assign sub_push[g] = push_ok && (push_sub == SUB_W'(g));
        assign sub_pop[g]  = pop_fire && grant_oh[g];

        iq_stack #(.DEPTH(DEPTH)) u_stack (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (sub_push[g]),
            .pop        (sub_pop[g]),
            .push_entry (new_entry),
            .top_entry  (tops[g]),
            .count      (cnt[g])
        );
    end

    always_comb begin
        r_d     = r_q;
        r_d.err = (push_valid && !push_ok) || (svc_req && !io_enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    iq_entry_t sel_entry;
    assign sel_entry    = grant_valid ? tops[grant_idx] : '0;
    assign out_valid    = grant_valid;
    assign out_subclass = grant_idx;
    assign out_id       = sel_entry.id;
    assign out_nr       = sel_entry.nr;
    assign out_parm     = sel_entry.parm;
    assign out_word     = sel_entry.word;
    assign pending      = |sub_busy;
    assign err          = r_q.err;

    // R8: service with I/O disabled reports an error next cycle
    a_r8_err_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !io_enable) |=> err);

    // R3: at most one subclass is granted
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh));

    // R9: nothing is presented while the summary is low
    a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> !out_valid);

    // R4 R10: a service with nothing deliverable leaves the summary alone
    a_r4_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && io_enable && !out_valid && !push_valid) |=> $stable(pending));
endmodule

// File: tb/test_io_irq_queue.sv
module test_io_irq_queue;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid;
    logic [15:0] push_id, push_nr;
    logic [31:0] push_parm, push_word;
    logic [63:0] ctrl_reg;
    logic        io_enable, svc_req;
    logic        out_valid;
    logic [2:0]  out_subclass;
    logic [15:0] out_id, out_nr;
    logic [31:0] out_parm, out_word;
    logic        pending, err;

    io_irq_queue #(.DEPTH(DEPTH)) i_io_irq_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_id(push_id),
        .push_nr(push_nr), .push_parm(push_parm), .push_word(push_word),
        .ctrl_reg(ctrl_reg), .io_enable(io_enable), .svc_req(svc_req),
        .out_valid(out_valid), .out_subclass(out_subclass), .out_id(out_id),
        .out_nr(out_nr), .out_parm(out_parm), .out_word(out_word),
        .pending(pending), .err(err)
    );

    always #2 clk = ~clk;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    logic [95:0] m_mem [8][DEPTH];
    int          m_cnt [8];
    logic        exp_err;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int model_sel(input logic [63:0] c);
        for (int s = 0; s < 8; s++)
            if (m_cnt[s] > 0 && c[31 - s]) return s;
        return -1;
    endfunction

    function automatic logic [31:0] mk_word(input int sub, input logic [31:0] rnd);
        logic [31:0] w = rnd;
        w[29:27] = 3'(sub);
        return w;
    endfunction

    task automatic compare();
        int  s = model_sel(ctrl_reg);
        bit  any = 0;
        for (int k = 0; k < 8; k++) if (m_cnt[k] > 0) any = 1;
        chk(out_valid == (s >= 0), "R3 R4 R2 out_valid", 96'(out_valid), 96'(s >= 0));
        if (s >= 0) begin
            chk(out_subclass == 3'(s), "R3 R4 subclass", 96'(out_subclass), 96'(s));
            chk({out_id, out_nr, out_parm, out_word} == m_mem[s][m_cnt[s]-1], "R5 R6 entry",
                {out_id, out_nr, out_parm, out_word}, m_mem[s][m_cnt[s]-1]);
        end
        chk(pending == any, "R9 pending", 96'(pending), 96'(any));
        chk(err == exp_err, "R7 R8 R10 R11 err", 96'(err), 96'(exp_err));
    endtask

    task automatic step(input bit pv, input logic [31:0] pw, input logic [63:0] c,
                        input bit ioen, input bit svc);
        int  s, sub;
        bit  pop, ok;
        logic [95:0] e;
        compare();
        push_valid = pv;
        push_id    = 16'($urandom);
        push_nr    = 16'($urandom);
        push_parm  = $urandom;
        push_word  = pw;
        ctrl_reg   = c;
        io_enable  = ioen;
        svc_req    = svc;
        s   = model_sel(c);
        pop = svc && ioen && (s >= 0);
        sub = int'(pw[29:27]);
        ok  = pv && (m_cnt[sub] < DEPTH || (pop && s == sub));
        exp_err = (pv && !ok) || (svc && !ioen);
        e = {push_id, push_nr, push_parm, push_word};
        if (pop) m_cnt[s]--;
        if (ok) begin
            m_mem[sub][m_cnt[sub]] = e;
            m_cnt[sub]++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [63:0] ALL_ON = 64'h0000_0000_FF00_0000;

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 8; k++) m_cnt[k] = 0;
        exp_err = 1'b0;
        rst_n = 1'b0; push_valid = 0; push_id = 0; push_nr = 0; push_parm = 0;
        push_word = 0; ctrl_reg = ALL_ON; io_enable = 1; svc_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(!pending && !out_valid && !err, "R1 reset outputs",
            96'({pending, out_valid, err}), 96'(0));

        // R7 overrun on subclass 2, then R5 drain in reverse order, R10 empty service
        for (int i = 0; i < DEPTH + 1; i++) step(1, mk_word(2, $urandom), ALL_ON, 1, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, ALL_ON, 1, 1);
        step(0, 0, ALL_ON, 1, 1);
        step(0, 0, ALL_ON, 1, 0);

        // R4 masked subclass kept; R2 enable bit mapping (subclass 3 -> bit 28 only)
        step(1, mk_word(1, $urandom), 64'h1000_0000, 1, 0);
        step(1, mk_word(3, $urandom), 64'h1000_0000, 1, 0);
        step(0, 0, 64'h1000_0000, 1, 1);
        step(0, 0, 64'h1000_0000, 1, 1);
        step(0, 0, 64'h1000_0000, 1, 0);
        chk(pending && !out_valid, "R4 masked entry held", 96'({pending, out_valid}), 96'(2'b10));
        step(0, 0, 64'h4000_0000, 1, 1);
        step(0, 0, 64'h4000_0000, 1, 0);
        chk(!pending, "R9 summary clears", 96'(pending), 96'(0));

        // R8 service while I/O disabled
        step(1, mk_word(6, $urandom), ALL_ON, 1, 0);
        step(0, 0, ALL_ON, 0, 1);
        step(0, 0, ALL_ON, 1, 0);
        chk(pending && out_subclass == 3'd6, "R8 entry not popped",
            96'({pending, out_subclass}), 96'({1'b1, 3'd6}));

        // R11 push and pop of the same full subclass
        for (int i = 0; i < DEPTH - 1; i++) step(1, mk_word(6, $urandom), ALL_ON, 1, 0);
        step(1, mk_word(6, $urandom), ALL_ON, 1, 1);
        step(0, 0, ALL_ON, 1, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, ALL_ON, 1, 1);

        // priority and mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] c = {32'($urandom), 8'($urandom), 24'($urandom)};
            bit drain = (n % 500) > 440;
            if (n % 7 == 0) c[31:24] = 8'hFF;
            step(!drain && ($urandom % 3 != 0), mk_word($urandom % 8, $urandom),
                 drain ? ALL_ON : c, ($urandom % 8) != 0, ($urandom % 2) == 0 || drain);
        end
        compare();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule